// File: doc/BRIEF.md
# Clause-22 Style PHY Management Controller

This block lets a host reach the registers of an Ethernet PHY over the two-wire management bus: a clock output (MDC) and a bidirectional data line (MDIO, split here into output, output enable and input). The host programs four small registers over a simple word-wide register port. A write to the command register with its go bit set sends one complete management frame. During the frame the command register's go bit reads back as 1, and it clears by itself when the last bit has gone out.

The management clock is divided down from the system clock by a programmable divider. For a write, the host first loads the data register and then issues the command. For a read, the controller drives the frame header and then releases the line for the turnaround and the data. It samples the sixteen returned bits on rising MDC edges and leaves the result in the result register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write to address 0 with bit 0 set, while idle, makes bit 0 of address 0 read 1 from the next cycle on. It stays 1 for exactly 128*(div+1) system clocks, the length of one frame, and then reads 0.
- R2: Bit 1 of the command word selects the operation: 1 sends opcode 01 (write) and 0 sends opcode 10 (read).
- R3: The command word carries the PHY register address in bits 7:3 and the PHY address in bits 12:8. Reading address 0 returns these fields and bit 1 as last accepted, with bit 0 showing busy.
- R4: A write frame is 64 MDIO bits, all driven, sent MSB first: 32 ones, 01, 01, PHY address, register address, 10, then the 16 bits held at address 1.
- R5: A read frame drives its first 46 bits (preamble, 01, 10, PHY address, register address) and releases MDIO for the last 18 bits. The 16 bits sampled during the data phase appear at address 2, MSB first, once busy clears.
- R6: MDC has a period of 2*(div+1) system clocks, where div is the value at address 3, bits 7:0.
- R7: After reset, div holds the smallest value that keeps MDC at or below MDC_MAX_HZ for SYS_CLK_HZ. This is 9 with the defaults.
- R8: While busy, writes to address 0 or address 3 are ignored: fields, divider and the frame in progress are unchanged, and no second frame follows.
- R9: While idle, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 command, 1 write data, 2 read result, 3 divider |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The frame position is internal state. A miscount shows up as a wrong busy length at the command register, or as a header, opcode or data bit shifted at MDC rate within one frame. A wrong turnaround shows as the output enable still set at bits 46 and 47. A divider fault shows in the first MDC period. A lost busy lock shows as changed fields or divider, or as a second burst of MDC, within a few cycles after the frame ends. The bench records every MDC rising edge with a PHY model and compares each full frame and the measured period against values rebuilt from the requirements.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    // register select codes
    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_WDAT = 2'd1;
    localparam logic [1:0] ADDR_RDAT = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    // command word layout
    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_REG_LSB = 3;
    localparam int CMD_PHY_LSB = 8;

    localparam int ADR_W  = 5;
    localparam int WORD_W = 16;
    localparam int PRE_LEN = 32;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cdiv_t;

    cdiv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (st_q.cnt == div) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
            rise     = ~st_q.mdc;
            fall     = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [ADR_W-1:0]  phy_adr,
    input  logic [ADR_W-1:0]  reg_adr,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [WORD_W-1:0] rx_word
);
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADR_W + 2 + WORD_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = FRAME_LEN - WORD_W - 2;
    localparam int DATA_POS  = FRAME_LEN - WORD_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(TA_POS);
    localparam logic [CNT_W-1:0] DATA_BIT = CNT_W'(DATA_POS);

    typedef struct packed {
        eng_state_e           state;
        logic                 wr;
        logic [CNT_W-1:0]     bitn;
        logic [FRAME_LEN-1:0] frame;
        logic [WORD_W-1:0]    rx;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        case (st_q.state)
            ENG_IDLE: begin
                if (start) begin
                    st_d.state = ENG_RUN;
                    st_d.wr    = is_wr;
                    st_d.bitn  = '0;
                    st_d.frame = {{PRE_LEN{1'b1}}, 2'b01,
                                  (is_wr ? 2'b01 : 2'b10),
                                  phy_adr, reg_adr,
                                  (is_wr ? 2'b10 : 2'b11),
                                  (is_wr ? tx_word : {WORD_W{1'b1}})};
                end
            end
            default: begin
                if (rise && !st_q.wr && st_q.bitn >= DATA_BIT)
                    st_d.rx = {st_q.rx[WORD_W-2:0], mdio_i};
                if (fall) begin
                    if (st_q.bitn == LAST_BIT) begin
                        st_d.state = ENG_IDLE;
                        done       = 1'b1;
                    end else begin
                        st_d.bitn  = st_q.bitn + 1'b1;
                        st_d.frame = {st_q.frame[FRAME_LEN-2:0], 1'b1};
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ENG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state == ENG_RUN);
    assign mdio_o  = busy ? st_q.frame[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = busy && (st_q.wr || st_q.bitn < TA_BIT);
    assign rx_word = st_q.rx;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
#(
    parameter int             DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output logic              start,
    output logic              start_wr,
    output logic [ADR_W-1:0]  start_phy,
    output logic [ADR_W-1:0]  start_reg,
    output logic              ctrl_wr,
    output logic [ADR_W-1:0]  ctrl_phy,
    output logic [ADR_W-1:0]  ctrl_reg,
    output logic [WORD_W-1:0] tx_word,
    output logic [DIV_W-1:0]  div_val
);
    typedef struct packed {
        logic              wr;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  rga;
        logic [WORD_W-1:0] txd;
        logic [WORD_W-1:0] rxd;
        logic [DIV_W-1:0]  div;
    } regs_t;

    regs_t st_d, st_q;

    assign start_wr  = reg_wdata[CMD_WR_BIT];
    assign start_phy = reg_wdata[CMD_PHY_LSB +: ADR_W];
    assign start_reg = reg_wdata[CMD_REG_LSB +: ADR_W];

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CMD: if (!busy) begin
                    st_d.wr  = start_wr;
                    st_d.phy = start_phy;
                    st_d.rga = start_reg;
                    start    = reg_wdata[CMD_GO_BIT];
                end
                ADDR_WDAT: st_d.txd = reg_wdata;
                ADDR_DIV:  if (!busy) st_d.div = reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
        if (done && !st_q.wr)
            st_d.rxd = rx_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.div <= DIV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CMD: begin
                reg_rdata[CMD_GO_BIT]              = busy;
                reg_rdata[CMD_WR_BIT]              = st_q.wr;
                reg_rdata[CMD_REG_LSB +: ADR_W]    = st_q.rga;
                reg_rdata[CMD_PHY_LSB +: ADR_W]    = st_q.phy;
            end
            ADDR_WDAT: reg_rdata = st_q.txd;
            ADDR_RDAT: reg_rdata = st_q.rxd;
            default:   reg_rdata[DIV_W-1:0] = st_q.div;
        endcase
    end

    assign ctrl_wr  = st_q.wr;
    assign ctrl_phy = st_q.phy;
    assign ctrl_reg = st_q.rga;
    assign tx_word  = st_q.txd;
    assign div_val  = st_q.div;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int DIV_CALC = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ) - 1;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_CALC < 0 ? 0 : DIV_CALC);

    logic              busy, done, start, start_wr;
    logic              rise, fall;
    logic [ADR_W-1:0]  start_phy, start_reg;
    logic              ctrl_wr;
    logic [ADR_W-1:0]  ctrl_phy, ctrl_reg;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic [DIV_W-1:0]  div_val;

    mdio_host_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .rx_word(rx_word),
        .start(start), .start_wr(start_wr), .start_phy(start_phy), .start_reg(start_reg),
        .ctrl_wr(ctrl_wr), .ctrl_phy(ctrl_phy), .ctrl_reg(ctrl_reg),
        .tx_word(tx_word), .div_val(div_val)
    );

    mdio_clk_div #(.DIV_W(DIV_W)) u_cdiv (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_val),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .is_wr(start_wr),
        .phy_adr(start_phy), .reg_adr(start_reg), .tx_word(tx_word),
        .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rx_word(rx_word)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_go,
    input logic             rd_busy,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             busy,
    input logic             ctrl_wr,
    input logic [4:0]       ctrl_phy,
    input logic [4:0]       ctrl_reg,
    input logic [DIV_W-1:0] div_val
);
    logic             mdc_p, busy_p;
    logic [DIV_W+1:0] hold_q, hold_now;

    assign hold_now = (mdc != mdc_p || (busy && !busy_p)) ? 1
                    : (&hold_q ? hold_q : hold_q + 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_p  <= 1'b0;
            busy_p <= 1'b0;
            hold_q <= '0;
        end else begin
            mdc_p  <= mdc;
            busy_p <= busy;
            hold_q <= hold_now;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && reg_wr && reg_addr == 2'd0 && reg_go |=> busy); // R1
    AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd0 |-> rd_busy == busy); // R1
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctrl_wr |-> mdio_oe); // R4
    AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> hold_now <= {2'b00, div_val} + 1'b1); // R6
    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr && reg_addr == 2'd0 |=> $stable(ctrl_wr) && $stable(ctrl_phy) && $stable(ctrl_reg)); // R8
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr && reg_addr == 2'd3 |=> $stable(div_val)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe); // R9
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_go(reg_wdata[0]), .rd_busy(reg_rdata[0]),
    .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy),
    .ctrl_wr(ctrl_wr), .ctrl_phy(ctrl_phy), .ctrl_reg(ctrl_reg), .div_val(div_val)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned cyc = 0;
    int unsigned wd = 0;

    // PHY model state
    int          pidx = 64;
    logic        model_read = 1'b0;
    logic [15:0] phy_rd = 16'd0;
    logic [63:0] cap_o, cap_oe;
    int unsigned e_cyc0, e_cyc1;

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        if (pidx < 64) begin
            cap_o[63-pidx]  = mdio_o;
            cap_oe[63-pidx] = mdio_oe;
            if (pidx == 0) e_cyc0 = cyc;
            if (pidx == 1) e_cyc1 = cyc;
            pidx = pidx + 1;
        end
    end

    always @(negedge mdc) begin
        if (model_read && pidx == 47) mdio_i = 1'b0;
        else if (model_read && pidx >= 48 && pidx <= 63) mdio_i = phy_rd[63-pidx];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
    endfunction

    task automatic txn(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] d, input logic [7:0] dv, input bit poke);
        logic [15:0] r;
        logic [63:0] ef;
        int          busy_cnt;
        bit          busy_ok;
        ef = exp_frame(wr, phy, ra, d);
        reg_write(2'd3, {8'd0, dv});
        reg_read(2'd3, r);
        check(r == {8'd0, dv}, "R6 divider readback", r, dv);
        reg_write(2'd1, d);
        phy_rd = d; model_read = !wr; mdio_i = 1'b1;
        cap_o = '0; cap_oe = '0; pidx = 0;
        reg_write(2'd0, {3'b000, phy, ra, 1'b0, wr, 1'b1});
        busy_cnt = 128 * (dv + 1);
        busy_ok = 1'b1;
        for (int i = 0; i < busy_cnt; i++) begin
            if (poke && i == 30) begin
                reg_addr = 2'd0; reg_wdata = {3'b000, ~phy, ~ra, 1'b0, ~wr, 1'b1}; reg_wr = 1'b1;
            end else if (poke && i == 31) begin
                reg_addr = 2'd3; reg_wdata = 16'd5; reg_wr = 1'b1;
            end else begin
                reg_wr = 1'b0;
                reg_read(2'd0, r);
                if (r[0] !== 1'b1) busy_ok = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        reg_read(2'd0, r);
        check(busy_ok && r[0] == 1'b0, "R1 busy window", {63'd0, r[0]}, {63'd0, busy_ok});
        check(r[12:1] == {phy, ra, 1'b0, wr}, "R3 command fields readback", r, {phy, ra, 1'b0, wr, 1'b0});
        check(e_cyc1 - e_cyc0 == 2 * (dv + 1), "R6 MDC period", e_cyc1 - e_cyc0, 2 * (dv + 1));
        check(pidx == 64, "R4 frame bit count", pidx, 64);
        if (wr) begin
            check(cap_oe == '1, "R4 write drive", cap_oe, '1);
            check(cap_o == ef, "R2 R4 write frame", cap_o, ef);
        end else begin
            check(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R5 read release", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
            check(cap_o[63:18] == ef[63:18], "R2 R5 read header", cap_o[63:18], ef[63:18]);
            reg_read(2'd2, r);
            check(r == d, "R5 read result", r, d);
        end
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle quiet", {mdc, mdio_oe}, 0);
        if (poke) begin
            reg_read(2'd3, r);
            check(r == {8'd0, dv}, "R8 divider locked", r, dv);
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (mdc !== 1'b0 || pidx != 64) busy_ok = 1'b0;
            end
            reg_read(2'd0, r);
            check(busy_ok && r[0] == 1'b0, "R8 no second frame", {63'd0, r[0]}, 0);
        end
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(2'd0, r);
        check(r == 16'd0, "R1 reset command", r, 0);
        reg_read(2'd3, r);
        check(r == 16'd9, "R7 reset divider", r, 9);
        reg_read(2'd2, r);
        check(r == 16'd0, "R5 reset result", r, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 reset quiet", {mdc, mdio_oe}, 0);

        // directed corners
        txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 8'd0, 1'b0);
        txn(1'b0, 5'd0,  5'd0,  16'h0000, 8'd0, 1'b0);
        txn(1'b0, 5'd1,  5'd1,  16'hA5C3, 8'd9, 1'b0);
        txn(1'b1, 5'd10, 5'd21, 16'h0001, 8'd1, 1'b1);
        txn(1'b0, 5'd6,  5'd17, 16'h8000, 8'd2, 1'b1);

        // random traffic
        for (int t = 0; t < 12; t++) begin
            txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                8'($urandom % 4), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule